// File: doc/BRIEF.md
# Bit-Serial Secure Memory Card Controller

This block is the card-side control logic for a bit-addressed nonvolatile memory reached over a contact interface. The interface has a card reset, a card clock, a program-select pin and one open-drain data line. A fast system clock samples all four pins. The pin levels and an internal bit address pick the operation on each card-clock edge. The operations are reset, advance-and-read, advance-and-compare, erase/write and standby.

The address range holds one security code field and three key fields. Inside those fields the block never drives the line. Instead it latches the host's bit on each falling card-clock edge and checks that bit against the stored bit on the following falling edge. A wrong security code bit blocks all reading and programming until the next card reset. A key field matched in full unlocks erasure of that key's zone. Programming needs the card clock held high for a minimum number of system cycles. If the clock falls earlier, the operation is aborted. The data line is modelled as an output-enable and data-out pair plus a data-in signal that sees the resolved wire.

Top module: `scc_card_ctrl`

## Requirements
- R1: While card reset is high and card clock is high (standby), the bit address holds and the data line is released. When reset drops and the clock then falls, the address advances from the value it held.
- R2: Card reset high with card clock low clears the address to 0, the three erase flags and the security failure flag. Once reset is low again, bit 0 is driven on the data line.
- R3: With reset and program low, each falling card-clock edge advances the address by one. From the last bit (NUM_BITS-1), one more falling edge wraps the address to 0.
- R4: Outside the compare fields, the newly addressed bit is driven after each falling edge. It stays driven through the following high phase, except as stated in R5.
- R5: On the bit just before a code or key field, the data line is driven only while card clock is low. It is released while card clock is high.
- R6: On addresses inside a code or key field, the data line is never driven. The host level is latched on the falling edge and compared with the stored bit on the next falling edge.
- R7: A mismatch in the security code field latches a failure. The line then stays released at every address and programming has no effect, until the next card reset. A fully correct code leaves reading enabled.
- R8: A full match of key field k sets erase flag k. An erase of a bit inside zone k takes effect only while that flag is set. A key with any wrong bit leaves the flag clear.
- R9: With program high, the line level at the rising card-clock edge picks the operation: 1 erases (bit becomes 1) and 0 writes (bit becomes 0). The operation commits at the falling edge if the clock was high for at least PROG_CYCLES system cycles. The address does not advance, and the resulting bit is driven after the fall.
- R10: If card clock falls before PROG_CYCLES system cycles have passed, the operation is aborted and the bit keeps its old value.
- R11: After system reset the array holds, at bit address a, the value a[0] XOR a[2].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, samples all card pins |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| card_clk_i | input | 1 | Card clock pin (asynchronous) |
| card_rst_i | input | 1 | Card reset pin (asynchronous) |
| card_pgm_i | input | 1 | Program-select pin (asynchronous) |
| io_di_i | input | 1 | Resolved level of the data line |
| io_do_o | output | 1 | Data driven onto the line when enabled |
| io_oe_o | output | 1 | Drive enable for the data line |

## Verification
The bench builds the block with a 64-bit array. The security code sits at bits 8 to 11 and the three keys at 16, 28 and 40, each four bits long, with eight-bit erase zones behind them. A programming minimum of 16 cycles lets a short clock-high phase abort and a long one commit. With these values a full address wrap, passes through every field, key unlock and relock across card reset, and the sticky code failure all fit in short walks of the card clock.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int PIN_CLK  = 0;
  localparam int PIN_RST  = 1;
  localparam int PIN_PGM  = 2;
  localparam int PIN_IO   = 3;
  localparam int NUM_PINS = 4;
  localparam int NUM_KEYS = 3;

  // power-on content of the array
  function automatic logic init_bit(input logic [31:0] a);
    return a[0] ^ a[2];
  endfunction
endpackage

// File: rtl/scc_pin_sync.sv
module scc_pin_sync #(
  parameter int            N       = 4,
  parameter logic [N-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic ff1_q, ff2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff1_q <= RST_VAL[g];
        ff2_q <= RST_VAL[g];
      end else begin
        ff1_q <= pin_i[g];
        ff2_q <= ff1_q;
      end
    end
    assign lvl_o[g] = ff2_q;
  end
endmodule

// File: rtl/scc_addr_ctr.sv
module scc_addr_ctr #(
  parameter int NUM_BITS = 1600,
  localparam int AW = $clog2(NUM_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LAST = AW'(NUM_BITS - 1);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (adv_i)  addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
  end
  assign addr_o = addr_q;

  AST_ADDR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni) (adv_i && !clr_i && addr_q == LAST) |=> addr_q == '0); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (!adv_i && !clr_i) |=> $stable(addr_q)); // R1
endmodule

// File: rtl/scc_prog_timer.sv
module scc_prog_timer #(
  parameter int PROG_CYCLES = 400000,
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mode_i,
  input  logic fall_i,
  input  logic cancel_i,
  output logic busy_o,
  output logic erase_o,
  output logic ripe_o
);
  localparam logic [CW-1:0] LIMIT = CW'(PROG_CYCLES);
  logic [CW-1:0] cnt_q;
  logic          busy_q, erase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cancel_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      erase_q <= mode_i;
      cnt_q   <= '0;
    end else if (fall_i) begin
      busy_q <= 1'b0;
    end else if (busy_q && cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign erase_o = erase_q;
  assign ripe_o  = busy_q && (cnt_q == LIMIT);

  AST_RIPE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) ripe_o |-> $past(busy_q)); // R10
endmodule

// File: rtl/scc_bit_mem.sv
module scc_bit_mem #(
  parameter int NUM_BITS = 1600,
  localparam int AW = $clog2(NUM_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic          wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic          rdata_a_o,
  output logic          rdata_b_o
);
  logic mem_q [NUM_BITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BITS; i++) mem_q[i] <= scc_pkg::init_bit(32'(i));
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_a_o <= 1'b0;
      rdata_b_o <= 1'b0;
    end else begin
      rdata_a_o <= mem_q[raddr_a_i];
      rdata_b_o <= mem_q[raddr_b_i];
    end
  end
endmodule

// File: rtl/scc_card_ctrl.sv
module scc_card_ctrl #(
  parameter int unsigned NUM_BITS    = 1600,
  parameter int unsigned PROG_CYCLES = 400000,
  parameter int unsigned SC_LO = 80,   parameter int unsigned SC_HI = 95,
  parameter int unsigned K0_LO = 96,   parameter int unsigned K0_HI = 127,
  parameter int unsigned K1_LO = 128,  parameter int unsigned K1_HI = 159,
  parameter int unsigned K2_LO = 160,  parameter int unsigned K2_HI = 191,
  parameter int unsigned Z0_LO = 512,  parameter int unsigned Z0_HI = 799,
  parameter int unsigned Z1_LO = 800,  parameter int unsigned Z1_HI = 1087,
  parameter int unsigned Z2_LO = 1088, parameter int unsigned Z2_HI = 1375
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic card_clk_i,
  input  logic card_rst_i,
  input  logic card_pgm_i,
  input  logic io_di_i,
  output logic io_do_o,
  output logic io_oe_o
);
  import scc_pkg::*;

  localparam int AW = $clog2(NUM_BITS);
  localparam int unsigned KEY_LO  [NUM_KEYS] = '{K0_LO, K1_LO, K2_LO};
  localparam int unsigned KEY_HI  [NUM_KEYS] = '{K0_HI, K1_HI, K2_HI};
  localparam int unsigned ZONE_LO [NUM_KEYS] = '{Z0_LO, Z1_LO, Z2_LO};
  localparam int unsigned ZONE_HI [NUM_KEYS] = '{Z0_HI, Z1_HI, Z2_HI};

  function automatic logic in_rng(input logic [AW-1:0] a, input int unsigned lo, input int unsigned hi);
    return (32'(a) >= lo) && (32'(a) <= hi);
  endfunction

  // pin synchronisation
  logic [NUM_PINS-1:0] pin_raw, pin_lvl;
  assign pin_raw[PIN_CLK] = card_clk_i;
  assign pin_raw[PIN_RST] = card_rst_i;
  assign pin_raw[PIN_PGM] = card_pgm_i;
  assign pin_raw[PIN_IO]  = io_di_i;

  scc_pin_sync #(.N(NUM_PINS), .RST_VAL(NUM_PINS'(1) << PIN_IO)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_raw),
    .lvl_o (pin_lvl)
  );

  logic clk_lvl, rst_lvl, pgm_lvl, io_lvl, clk_prev_q;
  assign clk_lvl = pin_lvl[PIN_CLK];
  assign rst_lvl = pin_lvl[PIN_RST];
  assign pgm_lvl = pin_lvl[PIN_PGM];
  assign io_lvl  = pin_lvl[PIN_IO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_prev_q <= 1'b0;
    else         clk_prev_q <= clk_lvl;
  end

  logic clk_rise, clk_fall, clr, adv;
  assign clk_rise = clk_lvl & ~clk_prev_q;
  assign clk_fall = ~clk_lvl & clk_prev_q;
  assign clr      = rst_lvl & ~clk_lvl;
  assign adv      = clk_fall & ~rst_lvl & ~pgm_lvl;

  // address counter
  logic [AW-1:0] addr;
  scc_addr_ctr #(.NUM_BITS(NUM_BITS)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .adv_i (adv),
    .addr_o(addr)
  );

  // field decode
  logic sc_hit, cmp_field, pre_field;
  logic [NUM_KEYS-1:0] key_hit, key_pre, zone_hit;
  assign sc_hit = in_rng(addr, SC_LO, SC_HI);
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_dec
    assign key_hit[k]  = in_rng(addr, KEY_LO[k], KEY_HI[k]);
    assign key_pre[k]  = (32'(addr) + 32'd1) == KEY_LO[k];
    assign zone_hit[k] = in_rng(addr, ZONE_LO[k], ZONE_HI[k]);
  end
  assign cmp_field = sc_hit | (|key_hit);
  assign pre_field = ((32'(addr) + 32'd1) == SC_LO) | (|key_pre);

  // compare pipeline: latch on one falling edge, check on the next
  logic          cmp_pend_q, cmp_val_q, cmp_rd, rd_q, do_cmp, cmp_match;
  logic [AW-1:0] cmp_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_pend_q <= 1'b0;
      cmp_val_q  <= 1'b0;
      cmp_addr_q <= '0;
    end else if (clr) begin
      cmp_pend_q <= 1'b0;
    end else if (clk_fall && !rst_lvl) begin
      cmp_pend_q <= adv & cmp_field;
      if (adv && cmp_field) begin
        cmp_val_q  <= io_lvl;
        cmp_addr_q <= addr;
      end
    end
  end

  assign do_cmp    = clk_fall & ~rst_lvl & cmp_pend_q;
  assign cmp_match = (cmp_val_q == cmp_rd);

  logic sc_fail_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                                  sc_fail_q <= 1'b0;
    else if (clr)                                                 sc_fail_q <= 1'b0;
    else if (do_cmp && in_rng(cmp_addr_q, SC_LO, SC_HI) && !cmp_match) sc_fail_q <= 1'b1;
  end

  logic [NUM_KEYS-1:0] eflag_q, run_q;
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    logic first, last, ok_now;
    assign first  = 32'(cmp_addr_q) == KEY_LO[k];
    assign last   = 32'(cmp_addr_q) == KEY_HI[k];
    assign ok_now = cmp_match & (first | run_q[k]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        run_q[k]   <= 1'b0;
        eflag_q[k] <= 1'b0;
      end else if (clr) begin
        run_q[k]   <= 1'b0;
        eflag_q[k] <= 1'b0;
      end else if (do_cmp && in_rng(cmp_addr_q, KEY_LO[k], KEY_HI[k])) begin
        run_q[k] <= ok_now;
        if (last && ok_now) eflag_q[k] <= 1'b1;
      end
    end

    AST_FLAG_FROM_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(eflag_q[k]) |-> $past(do_cmp)); // R8
  end

  // erase / write sequencing
  logic prog_start, prog_busy, prog_erase, prog_ripe, prog_ok, mem_we, shown_q;
  assign prog_start = clk_rise & pgm_lvl & ~rst_lvl;

  scc_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (prog_start),
    .mode_i  (io_lvl),
    .fall_i  (clk_fall),
    .cancel_i(rst_lvl),
    .busy_o  (prog_busy),
    .erase_o (prog_erase),
    .ripe_o  (prog_ripe)
  );

  assign prog_ok = ~sc_fail_q & (~prog_erase | ~(|(zone_hit & ~eflag_q)));
  assign mem_we  = clk_fall & ~rst_lvl & prog_ripe & prog_ok;

  // after a programming fall the result is shown while PGM stays high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     shown_q <= 1'b0;
    else if (!pgm_lvl || prog_start) shown_q <= 1'b0;
    else if (clk_fall)               shown_q <= 1'b1;
  end

  scc_bit_mem #(.NUM_BITS(NUM_BITS)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (mem_we),
    .waddr_i  (addr),
    .wdata_i  (prog_erase),
    .raddr_a_i(addr),
    .raddr_b_i(cmp_addr_q),
    .rdata_a_o(rd_q),
    .rdata_b_o(cmp_rd)
  );

  // open-drain line control
  assign io_oe_o = ~rst_lvl & ~sc_fail_q & ~cmp_field & ~prog_busy
                 & (~pgm_lvl | shown_q) & ~(clk_lvl & pre_field);
  assign io_do_o = rd_q;

  AST_STANDBY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) rst_lvl |=> (addr == '0 || $stable(addr))); // R1
  AST_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni) clr |=> (eflag_q == '0 && !sc_fail_q)); // R2
  AST_PRE_RELEASE:  assert property (@(posedge clk_i) disable iff (!rst_ni) (clk_lvl && pre_field) |-> !io_oe_o); // R5
  AST_FIELD_QUIET:  assert property (@(posedge clk_i) disable iff (!rst_ni) cmp_field |-> !io_oe_o); // R6
  AST_FAIL_STICKY:  assert property (@(posedge clk_i) disable iff (!rst_ni) (sc_fail_q && !clr) |=> sc_fail_q); // R7
  AST_WRITE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_we |-> $past(clk_lvl)); // R9
endmodule

// File: tb/test_scc_card_ctrl.sv
module test_scc_card_ctrl;
  localparam int NB = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic card_clk = 1'b0, card_rst = 1'b0, card_pgm = 1'b0;
  logic host_en = 1'b0, host_val = 1'b0;
  logic io_do, io_oe, io_line;
  int   errors = 0, checks = 0, ta = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  assign io_line = io_oe ? io_do : (host_en ? host_val : 1'b1);

  scc_card_ctrl #(
    .NUM_BITS(NB), .PROG_CYCLES(16),
    .SC_LO(8),  .SC_HI(11),
    .K0_LO(16), .K0_HI(19), .K1_LO(28), .K1_HI(31), .K2_LO(40), .K2_HI(43),
    .Z0_LO(20), .Z0_HI(27), .Z1_LO(32), .Z1_HI(39), .Z2_LO(44), .Z2_HI(51)
  ) i_scc_card_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .card_clk_i(card_clk),
    .card_rst_i(card_rst),
    .card_pgm_i(card_pgm),
    .io_di_i   (io_line),
    .io_do_o   (io_do),
    .io_oe_o   (io_oe)
  );

  function automatic logic pat(input int a);
    return a[0] ^ a[2];
  endfunction
  function automatic bit is_sc(input int a);
    return a >= 8 && a <= 11;
  endfunction
  function automatic bit is_key(input int a);
    return (a >= 16 && a <= 19) || (a >= 28 && a <= 31) || (a >= 40 && a <= 43);
  endfunction

  // {host_en, host_val, exp_oe_clk_high, exp_oe_after_fall, exp_do_after_fall}
  localparam logic [4:0] VEC [12] = '{
    5'b00111, 5'b00110, 5'b00111, 5'b00111, 5'b00110, 5'b00111,
    5'b00110, 5'b00000, 5'b10000, 5'b11000, 5'b10000, 5'b11011
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b (addr %0d)", req, what, act, exp, ta);
    end
  endtask

  task automatic tick(input bit drv, input bit val);
    host_en = drv; host_val = val;
    card_clk = 1'b1; wait_n(8);
    card_clk = 1'b0; wait_n(8);
    host_en = 1'b0;
    ta = (ta == NB - 1) ? 0 : ta + 1;
  endtask

  task automatic card_reset();
    card_rst = 1'b1; card_clk = 1'b0; wait_n(8);
    card_rst = 1'b0; wait_n(8);
    ta = 0;
  endtask

  task automatic walk(input int target, input bit key_ok);
    while (ta != target) begin
      if (is_sc(ta))       tick(1'b1, pat(ta));
      else if (is_key(ta)) tick(1'b1, key_ok ? pat(ta) : ~pat(ta));
      else                 tick(1'b0, 1'b0);
    end
  endtask

  task automatic prog(input bit erase, input int hold, input bit exp_oe, input bit exp_do, input string req);
    card_pgm = 1'b1; host_en = 1'b1; host_val = erase; wait_n(4);
    card_clk = 1'b1; wait_n(hold);
    card_clk = 1'b0; wait_n(4);
    host_en = 1'b0; wait_n(6);
    chk(req, io_oe, exp_oe, "oe after program fall");
    if (exp_oe) chk(req, io_do, exp_do, "bit after program");
    card_pgm = 1'b0; wait_n(8);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);

    // R2 reset presents bit 0
    card_reset();
    chk("R2", io_oe, 1'b1, "oe after reset");
    chk("R2", io_do, 1'b0, "bit 0 after reset");

    // R4 R5 R6 R11 table walk from address 0 through the code field
    for (int i = 0; i < 12; i++) begin
      host_en = VEC[i][4]; host_val = VEC[i][3];
      card_clk = 1'b1; wait_n(8);
      chk("R5", io_oe, VEC[i][2], "oe clock high");
      card_clk = 1'b0; wait_n(8);
      host_en = 1'b0;
      ta++;
      chk("R6", io_oe, VEC[i][1], "oe after fall");
      if (VEC[i][1]) chk("R4", io_do, VEC[i][0], "read bit (R11 pattern)");
    end
    tick(1'b0, 1'b0);
    chk("R7", io_oe, 1'b1, "read enabled after good code");
    chk("R11", io_do, pat(13), "bit 13");

    // R3 wrap
    walk(NB - 1, 1'b1);
    chk("R3", io_do, pat(NB - 1), "last bit");
    tick(1'b0, 1'b0);
    chk("R3", io_do, 1'b0, "bit 0 after wrap");
    tick(1'b0, 1'b0);
    chk("R3", io_do, 1'b1, "bit 1 after wrap");

    // R1 standby
    card_reset();
    walk(5, 1'b1);
    card_clk = 1'b1; wait_n(8);
    card_rst = 1'b1; wait_n(20);
    chk("R1", io_oe, 1'b0, "released in standby");
    card_rst = 1'b0; wait_n(8);
    card_clk = 1'b0; wait_n(8);
    ta = 6;
    chk("R1", io_oe, 1'b1, "oe after standby");
    chk("R1", io_do, pat(6), "address held then advanced");

    // R8 R9: wrong key, write then denied erase at bit 22
    card_reset();
    walk(22, 1'b0);
    chk("R11", io_do, 1'b1, "bit 22 initial");
    prog(1'b0, 40, 1'b1, 1'b0, "R9");
    prog(1'b1, 40, 1'b1, 1'b0, "R8");
    // correct key unlocks erase
    card_reset();
    walk(22, 1'b1);
    chk("R9", io_do, 1'b0, "address not moved by program");
    prog(1'b1, 40, 1'b1, 1'b1, "R8");
    // R10 early fall aborts
    prog(1'b0, 3, 1'b1, 1'b1, "R10");
    prog(1'b0, 40, 1'b1, 1'b0, "R9");
    // R2 reset relocks: wrong key after reset must not keep the flag
    card_reset();
    walk(22, 1'b0);
    prog(1'b1, 40, 1'b1, 1'b0, "R2");

    // R7 code failure
    card_reset();
    walk(9, 1'b1);
    tick(1'b1, ~pat(9));
    walk(12, 1'b1);
    chk("R7", io_oe, 1'b0, "read blocked after bad code");
    prog(1'b0, 40, 1'b0, 1'b0, "R7");
    tick(1'b0, 1'b0);
    chk("R7", io_oe, 1'b0, "still blocked");
    card_reset();
    walk(12, 1'b1);
    chk("R7", io_oe, 1'b1, "reset clears failure");
    chk("R7", io_do, 1'b1, "bit 12 unchanged");

    finish_run();
  end
endmodule